// File: doc/BRIEF.md
# SCSI Initiator Command Register Unit

This block is the host-facing byte register file and command dispatcher of a SCSI initiator controller. The host writes bytes into a write-side array and reads bytes from a separate read-side array. Both arrays are indexed by the address with its two low bits dropped, so a write and a read to the same address reach different storage. The write-side entries hold the parameters for the next operation: the transfer length and the target number. The read-side entries report status, interrupt cause and sequence step.

A write to the command entry decodes seven bits of the byte. Two commands act at once: a FIFO flush and a chip reset. Three kinds of command start a longer sub-operation: select-with-attention, transfer-information, and a message phase that sends two zero bytes. Each sub-operation is a request/done handshake with the logic outside the block. While one is running, the block reports busy and drops further command writes. When the done strobe arrives, a fixed pattern of status, interrupt and sequence values is loaded and an interrupt event is raised for one cycle toward the DMA block.

Top module: `scsi_cmd_regs`

## Requirements
- R1: The register index is host_addr[5:2]. host_rdata always returns the read-side entry at that index, with no cycle of latency. A host write stores into the write-side entry only, so reading the same index does not return the written byte.
- R2: After reset every read-side entry is 0x00, except entry 14, which holds the identification code 0x04. busy, the three request outputs, irq_event and dma_clear are all low.
- R3: A write to index 3 is a command. Only bits [6:0] choose it, so bit 7 has no effect on which command runs.
- R4: Command 0x01 (flush) sets read entry 5 to 0x08 and read entry 6 to 0x00 from the next cycle on. It leaves entry 4 as it was and raises no interrupt event.
- R5: Command 0x02 (chip reset) returns every read entry to its reset value (all 0x00, entry 14 = 0x04). It pulses dma_clear high for exactly the next cycle and raises no interrupt event.
- R6: Commands 0x42 and 0x43 raise sel_req from the next cycle until completion. sel_len is {write entry 1, write entry 0} and sel_target is write entry 4 bits [2:0]; both track those entries at all times.
- R7: On the cycle after sel_done is sampled with sel_req high, read entries 4/5/6 become 0x91/0x18/0x04. If sel_nodev was high at the same time, they become 0x80/0x20/0x00 instead.
- R8: Command 0x10 raises xfer_req. On the cycle after xfer_done is sampled with xfer_req high, entries 4/5/6 become 0x93/0x10/0x00.
- R9: Commands 0x11 and 0x12 raise msg_req. On the cycle after msg_done is sampled with msg_req high, entries 4/5/6 become 0x93/0x18/0x04 for 0x11 and 0x93/0x20/0x00 for 0x12.
- R10: Commands 0x00, 0x03 and 0x1A, and every code not named above, change no read entry, raise no request and raise no interrupt event.
- R11: busy is high exactly while a request is outstanding. While busy, a write to index 3 is discarded and runs no command. Writes to other indices are still stored. A done strobe for a phase that is not requested has no effect.
- R12: irq_event is high for exactly one cycle: the cycle after a sub-operation's done strobe is accepted, which is also the cycle in which the new read values first appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W (6) | Host byte address; bits [5:2] form the index |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_wdata | input | DATA_W (8) | Host write data |
| host_rdata | output | DATA_W (8) | Read-side entry at the current index |
| busy | output | 1 | A sub-operation is outstanding |
| sel_req | output | 1 | Select-with-attention request |
| sel_len | output | 2*DATA_W (16) | Transfer length {write entry 1, write entry 0} |
| sel_target | output | 3 | Target number from write entry 4 |
| sel_done | input | 1 | Selection finished |
| sel_nodev | input | 1 | Qualifies sel_done: no device answered |
| xfer_req | output | 1 | Transfer-information request |
| xfer_done | input | 1 | Transfer finished |
| msg_req | output | 1 | Status/message phase request (two zero bytes) |
| msg_done | input | 1 | Message phase finished |
| irq_event | output | 1 | One-cycle interrupt event toward the DMA block |
| dma_clear | output | 1 | One-cycle request to clear the DMA registers |

## Verification
The bench builds the block with its default ADDR_W of 6 and DATA_W of 8. That gives sixteen entries on each side, so the identification entry at index 14, the status triple at 4 to 6 and the length and target entries are all addressable, and every encoded result byte fits the data width. A behavioural model compares every output on every cycle while the bench walks through each command code. The walk includes commands issued during busy, done strobes for phases that are not requested, the nodev selection outcome and a chip reset that follows completed operations. The 16-bit length path is exercised with distinct low and high bytes, including a length change made while a selection is pending.

// File: rtl/scsi_cru_pkg.sv
package scsi_cru_pkg;

   localparam int CMD_W      = 7;
   localparam int IDX_LEN_LO = 0;
   localparam int IDX_LEN_HI = 1;
   localparam int IDX_CMD    = 3;
   localparam int IDX_STAT   = 4;
   localparam int IDX_INTR   = 5;
   localparam int IDX_SEQ    = 6;
   localparam int IDX_TARGET = 4;

   localparam logic [7:0] ST_SEL_OK   = 8'h91;
   localparam logic [7:0] ST_NODEV    = 8'h80;
   localparam logic [7:0] ST_PHASE_OK = 8'h93;
   localparam logic [7:0] IN_FUNC     = 8'h08;
   localparam logic [7:0] IN_SERVICE  = 8'h10;
   localparam logic [7:0] IN_SVC_FUNC = 8'h18;
   localparam logic [7:0] IN_DISC     = 8'h20;
   localparam logic [7:0] SQ_IDLE     = 8'h00;
   localparam logic [7:0] SQ_CMD_DONE = 8'h04;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_FLUSH,
      OP_CHIPRST,
      OP_SELECT,
      OP_XFER,
      OP_MSG
   } cru_op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SEL,
      PH_XFER,
      PH_MSG
   } cru_phase_e;

   typedef struct packed {
      logic [7:0] stat;
      logic [7:0] intr;
      logic [7:0] seq;
   } cru_result_t;

endpackage

// File: rtl/cru_cmd_decode.sv
module cru_cmd_decode
   import scsi_cru_pkg::*;
(
   input  logic [CMD_W-1:0] code,
   output cru_op_e          op,
   output logic             msg_accept
);

   always_comb begin
      op         = OP_NOP;
      msg_accept = 1'b0;
      case (code)
         7'h01: op = OP_FLUSH;
         7'h02: op = OP_CHIPRST;
         7'h10: op = OP_XFER;
         7'h11: op = OP_MSG;
         7'h12: begin
            op         = OP_MSG;
            msg_accept = 1'b1;
         end
         7'h42,
         7'h43: op = OP_SELECT;
         default: op = OP_NOP;
      endcase
   end

endmodule

// File: rtl/cru_phase_ctrl.sv
module cru_phase_ctrl
   import scsi_cru_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  cru_op_e     start_op,
   input  logic        start_accept,
   input  logic        sel_done,
   input  logic        sel_nodev,
   input  logic        xfer_done,
   input  logic        msg_done,
   output logic        busy,
   output logic        sel_req,
   output logic        xfer_req,
   output logic        msg_req,
   output logic        finish,
   output cru_result_t result,
   output logic        irq_event
);

   cru_phase_e phase_q;
   logic       accept_q;
   logic       irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         accept_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= finish;
         if (finish) begin
            phase_q <= PH_IDLE;
         end else if (start) begin
            accept_q <= start_accept;
            case (start_op)
               OP_SELECT: phase_q <= PH_SEL;
               OP_XFER:   phase_q <= PH_XFER;
               OP_MSG:    phase_q <= PH_MSG;
               default:   phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign sel_req   = (phase_q == PH_SEL);
   assign xfer_req  = (phase_q == PH_XFER);
   assign msg_req   = (phase_q == PH_MSG);
   assign busy      = (phase_q != PH_IDLE);
   assign irq_event = irq_q;
   assign finish    = (sel_req && sel_done) || (xfer_req && xfer_done) ||
                      (msg_req && msg_done);

   always_comb begin
      result = '{stat: ST_PHASE_OK, intr: IN_SVC_FUNC, seq: SQ_CMD_DONE};
      case (phase_q)
         PH_SEL:  result = sel_nodev ? '{stat: ST_NODEV, intr: IN_DISC, seq: SQ_IDLE}
                                     : '{stat: ST_SEL_OK, intr: IN_SVC_FUNC, seq: SQ_CMD_DONE};
         PH_XFER: result = '{stat: ST_PHASE_OK, intr: IN_SERVICE, seq: SQ_IDLE};
         PH_MSG:  result = accept_q ? '{stat: ST_PHASE_OK, intr: IN_DISC, seq: SQ_IDLE}
                                    : '{stat: ST_PHASE_OK, intr: IN_SVC_FUNC, seq: SQ_CMD_DONE};
         default: result = '{stat: ST_PHASE_OK, intr: IN_SVC_FUNC, seq: SQ_CMD_DONE};
      endcase
   end

   // R11: at most one phase request at a time
   a_r11_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_req, xfer_req, msg_req}));

   // R12: the interrupt event never lasts two cycles
   a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_event |=> !irq_event);

   // R12: an accepted done strobe drops the request and raises the event
   a_r12_done_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && sel_done) |=> (irq_event && !sel_req));

   // R11: a start only happens from idle
   a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/cru_regfile.sv
module cru_regfile
   import scsi_cru_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NREG     = 16,
   parameter int ID_INDEX = 14,
   parameter int ID_CODE  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(NREG)-1:0] wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [$clog2(NREG)-1:0] rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   input  logic                    chip_clear,
   input  logic                    flush,
   input  logic                    finish,
   input  cru_result_t             result,
   output logic [DATA_W-1:0]       len_lo,
   output logic [DATA_W-1:0]       len_hi,
   output logic [DATA_W-1:0]       target
);

   logic [NREG-1:0][DATA_W-1:0] rd_flat;
   logic [NREG-1:0][DATA_W-1:0] wr_flat;

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      localparam logic [DATA_W-1:0] INIT = DATA_W'((i == ID_INDEX) ? ID_CODE : 0);
      logic [DATA_W-1:0] rq;
      logic [DATA_W-1:0] wq;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rq <= INIT;
         end else if (chip_clear) begin
            rq <= INIT;
         end else if (finish && (i == IDX_STAT)) begin
            rq <= DATA_W'(result.stat);
         end else if (finish && (i == IDX_INTR)) begin
            rq <= DATA_W'(result.intr);
         end else if (finish && (i == IDX_SEQ)) begin
            rq <= DATA_W'(result.seq);
         end else if (flush && (i == IDX_INTR)) begin
            rq <= DATA_W'(IN_FUNC);
         end else if (flush && (i == IDX_SEQ)) begin
            rq <= DATA_W'(SQ_IDLE);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wq <= '0;
         end else if (wr_en && (wr_idx == i)) begin
            wq <= wr_data;
         end
      end

      assign rd_flat[i] = rq;
      assign wr_flat[i] = wq;
   end

   assign rd_data = rd_flat[rd_idx];
   assign len_lo  = wr_flat[IDX_LEN_LO];
   assign len_hi  = wr_flat[IDX_LEN_HI];
   assign target  = wr_flat[IDX_TARGET];

   // R5: chip reset restores the identification entry
   a_r5_id_restored: assert property (@(posedge clk) disable iff (!rst_n)
      chip_clear |=> (rd_flat[ID_INDEX] == DATA_W'(ID_CODE)));

   // R4: flush loads the function-complete interrupt code
   a_r4_flush_intr: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !chip_clear) |=> (rd_flat[IDX_INTR] == DATA_W'(IN_FUNC)));

   // R7: completion loads the status byte presented with it
   a_r7_stat_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !chip_clear) |=> (rd_flat[IDX_STAT] == DATA_W'($past(result.stat))));

endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
   import scsi_cru_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int ID_INDEX = 14,
   parameter int ID_CODE  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic                host_wr,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                busy,
   output logic                sel_req,
   output logic [2*DATA_W-1:0] sel_len,
   output logic [2:0]          sel_target,
   input  logic                sel_done,
   input  logic                sel_nodev,
   output logic                xfer_req,
   input  logic                xfer_done,
   output logic                msg_req,
   input  logic                msg_done,
   output logic                irq_event,
   output logic                dma_clear
);

   localparam int IDX_W = ADDR_W - 2;
   localparam int NREG  = 1 << IDX_W;

   initial begin
      assert (ADDR_W >= 6) else $error("ADDR_W must give at least 16 entries");
      assert (DATA_W >= 8) else $error("DATA_W must hold a full status byte");
      assert (ID_INDEX < NREG) else $error("ID_INDEX outside the register file");
   end

   logic [IDX_W-1:0] idx;
   logic             cmd_wr;
   logic             cmd_take;
   logic             start;
   logic             flush;
   logic             chip_clear;
   logic             reg_wr;
   logic             finish;
   logic             dma_clear_q;
   logic             msg_accept;
   cru_op_e          op;
   cru_result_t      result;
   logic [DATA_W-1:0] len_lo;
   logic [DATA_W-1:0] len_hi;
   logic [DATA_W-1:0] target;

   assign idx        = host_addr[ADDR_W-1:2];
   assign cmd_wr     = host_wr && (idx == IDX_W'(IDX_CMD));
   assign cmd_take   = cmd_wr && !busy;
   assign start      = cmd_take && ((op == OP_SELECT) || (op == OP_XFER) || (op == OP_MSG));
   assign flush      = cmd_take && (op == OP_FLUSH);
   assign chip_clear = cmd_take && (op == OP_CHIPRST);
   assign reg_wr     = host_wr && !(cmd_wr && busy);

   cru_cmd_decode u_decode (
      .code       (host_wdata[CMD_W-1:0]),
      .op         (op),
      .msg_accept (msg_accept)
   );

   cru_phase_ctrl u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_op     (op),
      .start_accept (msg_accept),
      .sel_done     (sel_done),
      .sel_nodev    (sel_nodev),
      .xfer_done    (xfer_done),
      .msg_done     (msg_done),
      .busy         (busy),
      .sel_req      (sel_req),
      .xfer_req     (xfer_req),
      .msg_req      (msg_req),
      .finish       (finish),
      .result       (result),
      .irq_event    (irq_event)
   );

   cru_regfile #(
      .DATA_W   (DATA_W),
      .NREG     (NREG),
      .ID_INDEX (ID_INDEX),
      .ID_CODE  (ID_CODE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_idx     (idx),
      .wr_data    (host_wdata),
      .rd_idx     (idx),
      .rd_data    (host_rdata),
      .chip_clear (chip_clear),
      .flush      (flush),
      .finish     (finish),
      .result     (result),
      .len_lo     (len_lo),
      .len_hi     (len_hi),
      .target     (target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_clear_q <= 1'b0;
      end else begin
         dma_clear_q <= chip_clear;
      end
   end

   assign dma_clear  = dma_clear_q;
   assign sel_len    = {len_hi, len_lo};
   assign sel_target = target[2:0];

   // R10: an unlisted code issued from idle starts nothing
   a_r10_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_take && (op == OP_NOP)) |=> !busy);

   // R11: a command write during busy leaves the request state alone
   a_r11_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy && !sel_done && !xfer_done && !msg_done) |=>
         ($stable(sel_req) && $stable(xfer_req) && $stable(msg_req) && !dma_clear));

   // R5: dma_clear is a single-cycle pulse
   a_r5_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dma_clear |=> !dma_clear);

   // R6: a selection command reaches the select request
   a_r6_sel_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op == OP_SELECT)) |=> sel_req);

endmodule

// File: tb/tb_scsi_cmd_regs.sv
module tb_scsi_cmd_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        busy, sel_req, xfer_req, msg_req, irq_event, dma_clear;
   logic [15:0] sel_len;
   logic [2:0]  sel_target;
   logic        sel_done = 1'b0, sel_nodev = 1'b0, xfer_done = 1'b0, msg_done = 1'b0;

   always #2 clk = ~clk;

   scsi_cmd_regs dut (
      .clk (clk), .rst_n (rst_n), .host_addr (host_addr), .host_wr (host_wr),
      .host_wdata (host_wdata), .host_rdata (host_rdata), .busy (busy),
      .sel_req (sel_req), .sel_len (sel_len), .sel_target (sel_target),
      .sel_done (sel_done), .sel_nodev (sel_nodev), .xfer_req (xfer_req),
      .xfer_done (xfer_done), .msg_req (msg_req), .msg_done (msg_done),
      .irq_event (irq_event), .dma_clear (dma_clear)
   );

   int vectors = 0;
   int errors = 0;
   bit finished = 1'b0;

   // behavioural reference: 0 idle, 1 select, 2 transfer, 3 message
   int rr[16];
   int wq[16];
   int ph;
   bit acc;
   bit irq_m;
   bit clr_m;

   task automatic model_reset();
      foreach (rr[i]) begin rr[i] = 0; wq[i] = 0; end
      rr[14] = 4; ph = 0; acc = 0; irq_m = 0; clr_m = 0;
   endtask

   task automatic set3(int s, int i, int q);
      rr[4] = s; rr[5] = i; rr[6] = q;
   endtask

   task automatic model_edge();
      int idx;
      bit was_busy;
      bit fin;
      idx = int'(host_addr) >> 2;
      was_busy = (ph != 0);
      fin = 0;
      irq_m = 0;
      clr_m = 0;
      if (ph == 1 && sel_done) begin
         fin = 1;
         if (sel_nodev) set3(8'h80, 8'h20, 0); else set3(8'h91, 8'h18, 4);
      end else if (ph == 2 && xfer_done) begin
         fin = 1; set3(8'h93, 8'h10, 0);
      end else if (ph == 3 && msg_done) begin
         fin = 1;
         if (acc) set3(8'h93, 8'h20, 0); else set3(8'h93, 8'h18, 4);
      end
      if (fin) begin ph = 0; irq_m = 1; end
      if (!was_busy && host_wr && idx == 3) begin
         case (int'(host_wdata) & 8'h7f)
            8'h01: begin rr[5] = 8'h08; rr[6] = 0; end
            8'h02: begin
               foreach (rr[i]) rr[i] = 0;
               rr[14] = 4; clr_m = 1;
            end
            8'h10: ph = 2;
            8'h11: begin ph = 3; acc = 0; end
            8'h12: begin ph = 3; acc = 1; end
            8'h42, 8'h43: ph = 1;
            default: ;
         endcase
      end
      if (host_wr && !(idx == 3 && was_busy)) wq[idx] = int'(host_wdata);
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "host_rdata", int'(host_rdata), rr[int'(host_addr) >> 2]);
      chk(tag, "busy", int'(busy), int'(ph != 0));
      chk(tag, "sel_req", int'(sel_req), int'(ph == 1));
      chk(tag, "xfer_req", int'(xfer_req), int'(ph == 2));
      chk(tag, "msg_req", int'(msg_req), int'(ph == 3));
      chk(tag, "irq_event", int'(irq_event), int'(irq_m));
      chk(tag, "dma_clear", int'(dma_clear), int'(clr_m));
      chk(tag, "sel_len", int'(sel_len), (wq[1] << 8) | wq[0]);
      chk(tag, "sel_target", int'(sel_target), wq[4] & 7);
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(int a, int d, string tag);
      host_addr = 6'(a); host_wdata = 8'(d); host_wr = 1'b1;
      step(tag);
      host_wr = 1'b0;
   endtask

   task automatic rd(int idx, string tag);
      host_addr = 6'(idx * 4);
      step(tag);
   endtask

   task automatic rd_status(string tag);
      rd(4, tag); rd(5, tag); rd(6, tag);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R2");
      for (int i = 0; i < 16; i++) rd(i, "R2");
      // R1: low address bits ignored, write side is separate storage
      for (int i = 0; i < 16; i++) begin host_addr = 6'(i * 4 + 3); step("R1"); end
      wr(8'h14, 8'h5a, "R1");
      host_addr = 6'h15; step("R1");
      wr(8'h00, 8'h34, "R6");
      wr(8'h04, 8'h12, "R6");
      wr(8'h10, 8'hfd, "R6");
      // R4: flush
      wr(8'h0c, 8'h01, "R4");
      rd_status("R4");
      // R6 / R7: selection with device present
      wr(8'h0c, 8'h42, "R6");
      repeat (3) step("R6");
      rd_status("R6");
      sel_done = 1'b1; step("R7"); sel_done = 1'b0;
      rd_status("R7");
      // R3: bit 7 set still decodes as flush
      wr(8'h0c, 8'h81, "R3");
      rd_status("R3");
      // R11: writes while busy
      wr(8'h0c, 8'h43, "R11");
      wr(8'h0c, 8'h10, "R11");
      wr(8'h0c, 8'h02, "R11");
      wr(8'h0c, 8'h01, "R11");
      wr(8'h00, 8'h80, "R11");
      xfer_done = 1'b1; msg_done = 1'b1; step("R11");
      xfer_done = 1'b0; msg_done = 1'b0;
      rd_status("R11");
      sel_done = 1'b1; sel_nodev = 1'b1; step("R7");
      sel_done = 1'b0; sel_nodev = 1'b0;
      rd_status("R7");
      step("R12");
      // R8: transfer information, foreign done ignored
      wr(8'h0c, 8'h10, "R8");
      sel_done = 1'b1; msg_done = 1'b1; step("R8");
      sel_done = 1'b0; msg_done = 1'b0;
      xfer_done = 1'b1; step("R8"); xfer_done = 1'b0;
      rd_status("R8");
      // R9: message phases
      wr(8'h0c, 8'h11, "R9");
      step("R9");
      msg_done = 1'b1; step("R9"); msg_done = 1'b0;
      rd_status("R9");
      wr(8'h0c, 8'h12, "R9");
      msg_done = 1'b1; step("R9"); msg_done = 1'b0;
      rd_status("R9");
      // R10: codes with no effect
      wr(8'h0c, 8'h00, "R10"); rd_status("R10");
      wr(8'h0c, 8'h03, "R10"); rd_status("R10");
      wr(8'h0c, 8'h1a, "R10"); rd_status("R10");
      wr(8'h0c, 8'h55, "R10"); rd_status("R10");
      wr(8'h0c, 8'h7f, "R10"); rd_status("R10");
      // R12: done strobes with nothing requested
      sel_done = 1'b1; xfer_done = 1'b1; msg_done = 1'b1; step("R12");
      sel_done = 1'b0; xfer_done = 1'b0; msg_done = 1'b0;
      step("R12");
      // R5: chip reset
      wr(8'h0c, 8'h02, "R5");
      step("R5");
      for (int i = 0; i < 16; i++) rd(i, "R5");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule